// File: doc/BRIEF.md
# Multi-Phase Peak Level Detector

This block watches the signed sample streams of up to three phase channels and, for each measurement window, finds the largest absolute sample among the phases taking part. The window length is not counted in clock cycles or samples. It is counted in half line periods: each pulse from an external zero-crossing detector on the reference phase moves a window counter on by one. That counter runs at all times, whether or not any phase is selected.

When the counter reaches the programmed length, the block latches the peak magnitude into the low 24 bits of a result word. Three flag bits above the magnitude mark which phase or phases held that peak. In the same cycle the block sets a status flag, and if the interrupt is enabled it pulls an active-low interrupt line. Software acknowledges the window by pulsing the status-clear input. Writing a new window length while any phase is selected restarts the count, so the first result after the write covers a whole window. One instance serves one channel type; a current channel and a voltage channel each use their own instance.

Top module: `pk_detect_top`

## Requirements
- R1: The magnitude of a 24-bit two's-complement sample is its absolute value. The most negative code 0x800000 saturates to 0x7FFFFF, so result bit 23 is always 0.
- R2: At the end of a window, result bits [23:0] hold the largest magnitude seen on any selected phase during that window. A sample presented in the same cycle as the ending zero-crossing pulse counts toward the window that is closing. Samples on unselected phases are ignored.
- R3: Result bits 24, 25 and 26 belong to phases A, B and C, which sit at sample bus bits [23:0], [47:24] and [71:48]. A phase's flag is 1 when that phase is selected and its window maximum equals the peak, and 0 otherwise. Phases that tie all get their flag set.
- R4: A window ends on the N-th zero-crossing pulse after it starts, where N is the programmed length; a length of 0 acts as 1. The result changes only at the end of a window.
- R5: The zero-crossing counter keeps counting while the phase-select field is 0. Windows still end, and they produce a result of 0 with no flags.
- R6: Writing the window length while any phase is selected restarts the count at zero. With no phase selected, the write changes only the length and the count carries on.
- R7: Each window starts from a peak of 0, so a result reflects only the samples of its own window.
- R8: The status flag is set at the end of every window. irq_n is low exactly when the status flag is set and irq_mask is 1.
- R9: A pulse on stat_clr clears the status flag, which releases irq_n high.
- R10: When a window ends in the same cycle as a status clear, the status flag stays set.
- R11: After reset the result is 0, the status flag is 0, irq_n is 1 and the window length is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample bus holds a new sample for every phase |
| smp_bus | input | 72 | Signed samples: A [23:0], B [47:24], C [71:48] |
| zx_pulse | input | 1 | One-cycle pulse per zero crossing of the reference phase |
| phase_sel | input | 3 | Phase enables for the peak search, bit 0 = A |
| len_wr | input | 1 | Write strobe for the window length |
| len_data | input | 8 | New window length in half line periods |
| irq_mask | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Clears the status flag |
| peak_result | output | 27 | Flags [26:24] and peak magnitude [23:0] |
| peak_status | output | 1 | Window-complete status flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The peak search runs with a single phase whose largest sample is negative, with three phases where a different phase wins, and with two phases that tie on opposite signs, so flag selection is separated from plain magnitude comparison. Further cases cover the saturating code 0x800000, a sample that arrives together with the closing pulse, and a large peak followed by a small window, which shows whether the running peak is cleared between windows. Window counting is tried with the default length, with a restart write mid-window, and with the same write while no phase is selected, which tells a count that restarts from one that carries on. The status tests cover the interrupt with and without the mask, and a clear that lands in the same cycle as a set.

// File: rtl/pk_pkg.sv
// Package pk_pkg: shared sizes for the peak level detector.
// Assumes samples are two's complement and phases are packed A first.
package pk_pkg;
    localparam int SMP_W   = 24;   // sample and magnitude width
    localparam int NPH     = 3;    // number of phases
    localparam int CNT_W   = 8;    // window length / counter width
    localparam int DEF_LEN = 16;   // window length after reset
endpackage

// File: rtl/pk_abs.sv
// Module pk_abs: combinational absolute value of one signed sample.
// Assumes W >= 2. The most negative code saturates to the largest
// positive magnitude, so the magnitude MSB is always 0.
module pk_abs #(
    parameter int W = 24
) (
    input  logic [W-1:0] smp,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    // magnitude with saturation of the single unrepresentable case
    always_comb begin
        if (!smp[W-1])
            mag = smp;
        else if (smp == MIN_NEG)
            mag = MAX_POS;
        else
            mag = ~smp + 1'b1;
    end
endmodule

// File: rtl/pk_window.sv
// Module pk_window: zero-crossing counter that frames measurement windows.
// The counter runs at all times. A length write restarts it only when a
// phase is selected. win_end pulses on the pulse that completes a window.
// A length of 0 behaves as 1.
module pk_window #(
    parameter int CW      = 8,
    parameter int DEF_LEN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zx,
    input  logic          wr,
    input  logic [CW-1:0] wr_len,
    input  logic          any_sel,
    output logic          win_end
);
    logic [CW-1:0] len_q;
    logic [CW-1:0] cnt_q;
    logic [CW:0]   cnt_inc;
    logic          restart;

    assign restart = wr && any_sel;
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    // a window closes on the pulse that brings the count up to the length
    assign win_end = zx && !restart && (cnt_inc >= {1'b0, len_q});

    // length register and half-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= CW'(DEF_LEN);
            cnt_q <= '0;
        end else begin
            if (wr)
                len_q <= wr_len;
            if (restart)
                cnt_q <= '0;
            else if (win_end)
                cnt_q <= '0;
            else if (zx)
                cnt_q <= cnt_inc[CW-1:0];
        end
    end

    // R6: a length write with a phase selected restarts the count
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R5: without a pulse or a restart the count holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!zx && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/pk_search.sv
// Module pk_search: running per-phase maxima and the peak/flags they give.
// peak_nxt and flags_nxt include the sample of the current cycle, so the
// top level can latch them in the cycle the window ends. Each maximum is
// cleared when the window ends. Unselected phases take no part.
module pk_search #(
    parameter int W   = 24,
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [NPH*W-1:0] smp_bus,
    input  logic [NPH-1:0] sel,
    input  logic           win_end,
    output logic [W-1:0]   peak_nxt,
    output logic [NPH-1:0] flags_nxt
);
    logic [W-1:0] mag      [NPH];
    logic [W-1:0] hold_q   [NPH];
    logic [W-1:0] hold_nxt [NPH];

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        pk_abs #(.W(W)) u_abs (
            .smp (smp_bus[p*W +: W]),
            .mag (mag[p])
        );

        // next running maximum for this phase
        assign hold_nxt[p] = (smp_valid && sel[p] && (mag[p] > hold_q[p]))
                             ? mag[p] : hold_q[p];

        // running maximum, restarted at every window boundary
        always_ff @(posedge clk) begin
            if (!rst_n || win_end)
                hold_q[p] <= '0;
            else
                hold_q[p] <= hold_nxt[p];
        end

        // R1: a stored magnitude never uses the sign position
        a_r1_hold_range: assert property (@(posedge clk) disable iff (!rst_n)
            !hold_q[p][W-1]);
    end

    // largest maximum among the selected phases, then the phases that hold it
    always_comb begin
        peak_nxt = '0;
        for (int p = 0; p < NPH; p++)
            if (sel[p] && (hold_nxt[p] > peak_nxt))
                peak_nxt = hold_nxt[p];
        for (int p = 0; p < NPH; p++)
            flags_nxt[p] = sel[p] && (hold_nxt[p] == peak_nxt);
    end
endmodule

// File: rtl/pk_detect_top.sv
// Module pk_detect_top: multi-phase peak level detector for one channel.
// It frames windows in half line periods, latches peak magnitude and phase
// flags at each window end, and drives a status flag and an active-low
// interrupt. Assumes zx_pulse is one cycle wide per zero crossing.
module pk_detect_top
    import pk_pkg::*;
#(
    parameter int W       = SMP_W,
    parameter int P       = NPH,
    parameter int CW      = CNT_W,
    parameter int LEN_RST = DEF_LEN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [P*W-1:0] smp_bus,
    input  logic           zx_pulse,
    input  logic [P-1:0]   phase_sel,
    input  logic           len_wr,
    input  logic [CW-1:0]  len_data,
    input  logic           irq_mask,
    input  logic           stat_clr,
    output logic [W+P-1:0] peak_result,
    output logic           peak_status,
    output logic           irq_n
);
    logic           win_end;
    logic [W-1:0]   peak_nxt;
    logic [P-1:0]   flags_nxt;
    logic [W+P-1:0] result_q;
    logic           status_q;

    pk_window #(.CW(CW), .DEF_LEN(LEN_RST)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .zx      (zx_pulse),
        .wr      (len_wr),
        .wr_len  (len_data),
        .any_sel (|phase_sel),
        .win_end (win_end)
    );

    pk_search #(.W(W), .NPH(P)) u_srch (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_bus   (smp_bus),
        .sel       (phase_sel),
        .win_end   (win_end),
        .peak_nxt  (peak_nxt),
        .flags_nxt (flags_nxt)
    );

    // result word latched once per window
    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (win_end)
            result_q <= {flags_nxt, peak_nxt};
    end

    // status flag: a window end sets it and wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (win_end)
            status_q <= 1'b1;
        else if (stat_clr)
            status_q <= 1'b0;
    end

    assign peak_result = result_q;
    assign peak_status = status_q;
    assign irq_n       = !(status_q && irq_mask);

    // R8 and R10: every window end leaves the status set
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> peak_status);

    // R9: a clear with no window end drops the status
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !win_end) |=> !peak_status);

    // R4: the result moves only at a window end
    a_r4_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(peak_result));

    // R3: no flag appears for a phase that was not selected
    a_r3_flag_sel: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> ((peak_result[W +: P] & ~$past(phase_sel)) == '0));

    // R1: the latched peak never has its top bit set
    a_r1_peak_range: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_result[W-1]);
endmodule

// File: tb/sim_pk_detect_top.sv
// Bench sim_pk_detect_top: directed scenarios for pk_detect_top.
// Inputs change on the falling edge; outputs are sampled on the falling edge.
module sim_pk_detect_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [71:0] smp_bus;
    logic        zx_pulse;
    logic [2:0]  phase_sel;
    logic        len_wr;
    logic [7:0]  len_data;
    logic        irq_mask;
    logic        stat_clr;
    logic [26:0] peak_result;
    logic        peak_status;
    logic        irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pk_detect_top u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bus(smp_bus),
        .zx_pulse(zx_pulse), .phase_sel(phase_sel), .len_wr(len_wr),
        .len_data(len_data), .irq_mask(irq_mask), .stat_clr(stat_clr),
        .peak_result(peak_result), .peak_status(peak_status), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of samples, optionally with a zero-crossing pulse
    task automatic put(input logic [23:0] a, input logic [23:0] b,
                       input logic [23:0] c, input logic with_zx);
        @(negedge clk);
        smp_bus   = {c, b, a};
        smp_valid = 1'b1;
        zx_pulse  = with_zx;
        @(negedge clk);
        smp_valid = 1'b0;
        zx_pulse  = 1'b0;
    endtask

    task automatic zx();
        @(negedge clk);
        zx_pulse = 1'b1;
        @(negedge clk);
        zx_pulse = 1'b0;
    endtask

    task automatic set_len(input logic [7:0] n);
        @(negedge clk);
        len_wr   = 1'b1;
        len_data = n;
        @(negedge clk);
        len_wr   = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 result", 32'(peak_result), 32'h0);
        check("R11 status", 32'(peak_status), 32'h0);
        check("R11 irq_n", 32'(irq_n), 32'h1);
        phase_sel = 3'b001;
        for (int i = 0; i < 15; i++) zx();
        check("R11 default length, 15 pulses", 32'(peak_status), 32'h0);
        zx();
        check("R11 default length, 16 pulses", 32'(peak_status), 32'h1);
        clr();
    endtask

    task automatic t_single();
        phase_sel = 3'b001;
        irq_mask  = 1'b1;
        set_len(8'd2);
        put(24'd100, 24'd5000, 24'd0, 1'b0);
        put(-24'sd300, 24'd6000, 24'd0, 1'b0);
        zx();
        check("R4 no end after 1 of 2", 32'(peak_status), 32'h0);
        put(24'd200, 24'd0, 24'd0, 1'b0);
        zx();
        check("R2 R3 single phase peak", 32'(peak_result), 32'h100012C);
        check("R8 status set", 32'(peak_status), 32'h1);
        check("R8 irq low with mask", 32'(irq_n), 32'h0);
        clr();
        check("R9 status cleared", 32'(peak_status), 32'h0);
        check("R9 irq released", 32'(irq_n), 32'h1);
    endtask

    task automatic t_multi();
        phase_sel = 3'b111;
        set_len(8'd1);
        put(24'd50, -24'sd1000, 24'd700, 1'b0);
        zx();
        check("R3 phase B wins", 32'(peak_result), {5'd0, 3'b010, 24'd1000});
        put(24'd500, 24'd3, -24'sd500, 1'b0);
        zx();
        check("R3 tie A and C, B flag cleared", 32'(peak_result), {5'd0, 3'b101, 24'd500});
        put(24'd9, 24'd4, 24'd900, 1'b1);
        check("R2 sample in closing cycle counts", 32'(peak_result), {5'd0, 3'b100, 24'd900});
    endtask

    task automatic t_sat();
        phase_sel = 3'b001;
        set_len(8'd0);
        put(24'h800000, 24'd0, 24'd0, 1'b0);
        zx();
        check("R1 saturate most negative", 32'(peak_result), {5'd0, 3'b001, 24'h7FFFFF});
        put(24'd10, 24'd0, 24'd0, 1'b0);
        zx();
        check("R7 peak restarts each window", 32'(peak_result), {5'd0, 3'b001, 24'd10});
        phase_sel = 3'b010;
        put(24'd0, 24'hFFFFFE, 24'd0, 1'b0);
        zx();
        check("R1 magnitude of -2", 32'(peak_result), {5'd0, 3'b010, 24'd2});
    endtask

    task automatic t_restart();
        phase_sel = 3'b001;
        set_len(8'd3);
        clr();
        zx(); zx();
        set_len(8'd3);
        zx(); zx();
        check("R6 restart with phase selected", 32'(peak_status), 32'h0);
        zx();
        check("R6 full window after restart", 32'(peak_status), 32'h1);
        clr();
        set_len(8'd3);
        phase_sel = 3'b000;
        zx(); zx();
        set_len(8'd3);
        zx();
        check("R5 count continues with no phase", 32'(peak_status), 32'h1);
        check("R5 empty result", 32'(peak_result), 32'h0);
    endtask

    task automatic t_mask_race();
        clr();
        irq_mask  = 1'b0;
        phase_sel = 3'b001;
        set_len(8'd1);
        zx();
        check("R8 status without mask", 32'(peak_status), 32'h1);
        check("R8 irq high when masked", 32'(irq_n), 32'h1);
        @(negedge clk);
        zx_pulse = 1'b1;
        stat_clr = 1'b1;
        @(negedge clk);
        zx_pulse = 1'b0;
        stat_clr = 1'b0;
        check("R10 set wins over clear", 32'(peak_status), 32'h1);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_bus = '0; zx_pulse = 1'b0;
        phase_sel = 3'b000; len_wr = 1'b0; len_data = '0;
        irq_mask = 1'b0; stat_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_sat();
        t_restart();
        t_mask_race();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule